// File: doc/BRIEF.md
# Boot Region Write Lockout Filter

This block guards the boot region of a 512K x 8 byte-addressed flash array. It keeps two lock slots, one for the bottom end of the address space and one for the top end. Each slot can freeze either a 16 KB or a 64 KB region. Every program or erase request the command sequencer wants to issue is presented to the filter together with its target address and kind. The filter answers in the same cycle whether the operation may go ahead.

A lock is set by a one-cycle request carrying a size code and a final address. The final address selects the end of memory. Lock state stands in for non-volatile storage and clears only on the global reset. While the device is in identification mode, reading either of two fixed probe addresses returns a status byte. That byte tells software which size of lock is active at that end.

Top module: `boot_lock_filter`

## Requirements
- R1: After reset both slots are unlocked, every valid operation is permitted, and both probe addresses read status 0x00.
- R2: A lock request with code 0x40 locks a 64 KB region: 0x70000-0x7FFFF at the top or 0x00000-0x0FFFF at the bottom. It takes effect from the cycle after the request.
- R3: A lock request with code 0x70 locks a 16 KB region: 0x7C000-0x7FFFF at the top or 0x00000-0x03FFF at the bottom.
- R4: The request's final address picks the slot. 0x7FFFF selects the top slot and 0x00000 selects the bottom slot.
- R5: A lock request with any other code, or with any other final address, changes nothing.
- R6: A byte program (op kind 0) is refused exactly when its address lies inside a locked region, and permitted anywhere else. permit_o is low whenever op_valid_i is low.
- R7: A page erase (op kind 1, the aligned 4 KB around the address) or a sector erase (op kind 2, the aligned 64 KB around the address) is refused as a whole if any byte of its range overlaps a locked region.
- R8: A chip erase (op kind 3) is refused if either slot is locked.
- R9: A lock request aimed at a slot that is already locked is ignored, whatever size it asks for.
- R10: When id_mode_i is high and probe_addr_i is 0x00002 (bottom) or 0x7FFF2 (top), probe_hit_o is high. stat_o[1:0] then reads 2'b10 for a 16 KB lock, 2'b11 for a 64 KB lock and 2'b00 for no lock. stat_o[7:2] always reads zero, and stat_o is 0x00 whenever probe_hit_o is low.
- R11: Locks stay set over any sequence of requests and clear only when rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous global reset, clears both locks |
| lock_req_i | input | 1 | One-cycle lock request strobe |
| lock_code_i | input | 8 | Lock size code (0x40 = 64 KB, 0x70 = 16 KB) |
| lock_addr_i | input | 19 | Final address of the lock request, selects top or bottom |
| op_valid_i | input | 1 | Program/erase candidate present |
| op_kind_i | input | 2 | 0 program, 1 page erase, 2 sector erase, 3 chip erase |
| op_addr_i | input | 19 | Target address of the candidate operation |
| id_mode_i | input | 1 | Device is in identification mode |
| probe_addr_i | input | 19 | Read address checked against the probe locations |
| permit_o | output | 1 | Candidate operation may proceed |
| probe_hit_o | output | 1 | Read address is a lock-status probe in identification mode |
| stat_o | output | 8 | Lock-status byte for the probed end |

## Verification
The bench programs at the last byte outside each locked region and at the first byte inside it. A design with an off-by-one window or a swapped 16K/64K width would mis-permit one of these. It issues page and sector erases whose base lies outside a lock but whose range reaches into it, which catches a filter that checks only the start address. It sends a second, larger lock to an already locked slot, along with requests with a wrong code or a near-miss final address, which exposes a slot that re-latches or decodes loosely. It also probes next to the probe addresses and outside identification mode, and checks that a reset in mid-run returns every region to writable.

// File: rtl/boot_lock_pkg.sv
package boot_lock_pkg;
  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_SMALL = 2'd1,
    LK_LARGE = 2'd2
  } lk_size_e;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_PAGE = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_kind_e;
endpackage

// File: rtl/lock_slot.sv
module lock_slot
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter bit          IS_TOP     = 1'b0,
  parameter logic [7:0]  CODE_LARGE = 8'h40,
  parameter logic [7:0]  CODE_SMALL = 8'h70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [7:0]        code_i,
  input  logic [ADDR_W-1:0] addr_i,
  output lk_size_e          size_o
);
  localparam logic [ADDR_W-1:0] TARGET = IS_TOP ? {ADDR_W{1'b1}} : '0;

  lk_size_e size_q, size_d;

  always_comb begin
    size_d = size_q;
    // first accepted request wins; slot is write-once until reset
    if (req_i && addr_i == TARGET && size_q == LK_NONE) begin
      if (code_i == CODE_LARGE)      size_d = LK_LARGE;
      else if (code_i == CODE_SMALL) size_d = LK_SMALL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) size_q <= LK_NONE;
    else         size_q <= size_d;
  end

  assign size_o = size_q;
endmodule

// File: rtl/region_hit.sv
module region_hit
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned SMALL_W = 14,
  parameter int unsigned LARGE_W = 16,
  parameter bit          IS_TOP  = 1'b0,
  localparam int unsigned OW     = $clog2(ADDR_W + 1)
) (
  input  lk_size_e          size_i,
  input  logic [OW-1:0]     op_w_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [OW-1:0] lk_w, span;
  logic          miss;

  // both ranges are aligned powers of two: overlap iff bits above the wider span match the end
  always_comb begin
    lk_w = '0;
    case (size_i)
      LK_SMALL: lk_w = OW'(SMALL_W);
      LK_LARGE: lk_w = OW'(LARGE_W);
      default:  lk_w = '0;
    endcase
    span = (op_w_i > lk_w) ? op_w_i : lk_w;
    miss = 1'b0;
    for (int i = 0; i < int'(ADDR_W); i++) begin
      if (i >= int'(span) && addr_i[i] != IS_TOP) miss = 1'b1;
    end
    hit_o = (size_i != LK_NONE) && !miss;
  end
endmodule

// File: rtl/probe_status.sv
module probe_status
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned PROBE_OFS = 2
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  lk_size_e          bot_size_i,
  input  lk_size_e          top_size_i,
  output logic              hit_o,
  output logic [7:0]        stat_o
);
  localparam logic [ADDR_W-1:0] BOT_PROBE = ADDR_W'(PROBE_OFS);
  localparam logic [ADDR_W-1:0] TOP_PROBE = ({ADDR_W{1'b1}} << 4) | ADDR_W'(PROBE_OFS);

  function automatic logic [1:0] enc(lk_size_e s);
    case (s)
      LK_SMALL: return 2'b10;
      LK_LARGE: return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction

  logic is_bot, is_top;

  always_comb begin
    is_bot = id_mode_i && addr_i == BOT_PROBE;
    is_top = id_mode_i && addr_i == TOP_PROBE;
    hit_o  = is_bot | is_top;
    stat_o = 8'h00;
    if (is_bot)      stat_o[1:0] = enc(bot_size_i);
    else if (is_top) stat_o[1:0] = enc(top_size_i);
  end
endmodule

// File: rtl/boot_lock_filter.sv
module boot_lock_filter
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned SMALL_W    = 14,
  parameter int unsigned LARGE_W    = 16,
  parameter int unsigned PAGE_W     = 12,
  parameter int unsigned SECT_W     = 16,
  parameter int unsigned PROBE_OFS  = 2,
  parameter logic [7:0]  CODE_LARGE = 8'h40,
  parameter logic [7:0]  CODE_SMALL = 8'h70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_req_i,
  input  logic [7:0]        lock_code_i,
  input  logic [ADDR_W-1:0] lock_addr_i,
  input  logic              op_valid_i,
  input  logic [1:0]        op_kind_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              permit_o,
  output logic              probe_hit_o,
  output logic [7:0]        stat_o
);
  localparam int unsigned OW = $clog2(ADDR_W + 1);

  lk_size_e      slot_size [2];
  logic    [1:0] slot_hit;
  logic [OW-1:0] op_w;
  logic    [1:0] bot_size, top_size;

  always_comb begin
    case (op_kind_e'(op_kind_i))
      OP_PROG: op_w = '0;
      OP_PAGE: op_w = OW'(PAGE_W);
      OP_SECT: op_w = OW'(SECT_W);
      default: op_w = OW'(ADDR_W);
    endcase
  end

  // slot 0 guards the bottom end, slot 1 the top end
  for (genvar g = 0; g < 2; g++) begin : g_slot
    lock_slot #(
      .ADDR_W(ADDR_W), .IS_TOP(g == 1),
      .CODE_LARGE(CODE_LARGE), .CODE_SMALL(CODE_SMALL)
    ) u_slot (
      .clk_i, .rst_ni,
      .req_i (lock_req_i),
      .code_i(lock_code_i),
      .addr_i(lock_addr_i),
      .size_o(slot_size[g])
    );

    region_hit #(
      .ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W), .IS_TOP(g == 1)
    ) u_hit (
      .size_i(slot_size[g]),
      .op_w_i(op_w),
      .addr_i(op_addr_i),
      .hit_o (slot_hit[g])
    );
  end

  probe_status #(.ADDR_W(ADDR_W), .PROBE_OFS(PROBE_OFS)) u_probe (
    .id_mode_i,
    .addr_i    (probe_addr_i),
    .bot_size_i(slot_size[0]),
    .top_size_i(slot_size[1]),
    .hit_o     (probe_hit_o),
    .stat_o
  );

  assign permit_o = op_valid_i & ~(|slot_hit);
  assign bot_size = slot_size[0];
  assign top_size = slot_size[1];
endmodule

// File: rtl/boot_lock_filter_chk.sv
module boot_lock_filter_chk #(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned SMALL_W = 14,
  parameter int unsigned LARGE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [1:0]        op_kind_i,
  input logic [ADDR_W-1:0] op_addr_i,
  input logic              permit_o,
  input logic              probe_hit_o,
  input logic [7:0]        stat_o,
  input logic [1:0]        bot_size,
  input logic [1:0]        top_size
);
  p_idle_no_permit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> !permit_o);

  p_top_large_block_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && top_size == 2'd2 && (&op_addr_i[ADDR_W-1:LARGE_W]) |-> !permit_o);

  p_bot_small_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && bot_size == 2'd1 && op_addr_i[ADDR_W-1:SMALL_W] == '0 |-> !permit_o);

  p_chip_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_kind_i == 2'd3 && (bot_size != 2'd0 || top_size != 2'd0) |-> !permit_o);

  p_top_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_size != 2'd0 |=> top_size == $past(top_size));

  p_bot_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bot_size != 2'd0 |=> bot_size == $past(bot_size));

  p_stat_upper_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[7:2] == 6'd0);

  p_stat_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !probe_hit_o |-> stat_o == 8'h00);
endmodule

bind boot_lock_filter boot_lock_filter_chk #(
  .ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W)
) u_chk (
  .clk_i, .rst_ni, .op_valid_i, .op_kind_i, .op_addr_i,
  .permit_o, .probe_hit_o, .stat_o, .bot_size, .top_size
);

// File: tb/sim_boot_lock_filter.sv
`timescale 1ns/1ps
module sim_boot_lock_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lock_req_i = 1'b0;
  logic [7:0]  lock_code_i = '0;
  logic [18:0] lock_addr_i = '0;
  logic        op_valid_i = 1'b0;
  logic [1:0]  op_kind_i = '0;
  logic [18:0] op_addr_i = '0;
  logic        id_mode_i = 1'b0;
  logic [18:0] probe_addr_i = '0;
  logic        permit_o, probe_hit_o;
  logic [7:0]  stat_o;

  always #2 clk_i = ~clk_i;

  boot_lock_filter u0 (.*);

  typedef struct {
    logic       permit;
    logic       hit;
    logic [7:0] stat;
    string      tag;
  } item_t;

  item_t sb[$];
  int    checks = 0, errors = 0;
  int    top_w = 0, bot_w = 0;  // 0 = unlocked, else log2 of locked size
  bit    done = 1'b0;

  function automatic logic exp_permit(int kind, int addr);
    int lo, hi, w;
    w  = (kind == 0) ? 0 : (kind == 1) ? 12 : (kind == 2) ? 16 : 19;
    lo = (addr >> w) << w;
    hi = lo + (1 << w) - 1;
    if (top_w != 0 && hi >= 'h80000 - (1 << top_w)) return 1'b0;
    if (bot_w != 0 && lo <= (1 << bot_w) - 1) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [1:0] enc(int w);
    return (w == 16) ? 2'b11 : (w == 14) ? 2'b10 : 2'b00;
  endfunction

  task automatic apply(input bit ov, input int kind, input int oaddr,
                       input bit id, input int paddr, input string tag);
    item_t it;
    @(negedge clk_i);
    op_valid_i = ov; op_kind_i = 2'(kind); op_addr_i = 19'(oaddr);
    id_mode_i = id;  probe_addr_i = 19'(paddr);
    #1;
    it.permit = ov && exp_permit(kind, oaddr);
    it.hit    = id && (paddr == 'h2 || paddr == 'h7FFF2);
    it.stat   = !it.hit ? 8'h00 : (paddr == 'h2) ? {6'd0, enc(bot_w)} : {6'd0, enc(top_w)};
    it.tag    = tag;
    sb.push_back(it);
  endtask

  task automatic op(input int kind, input int addr, input string tag);
    apply(1'b1, kind, addr, 1'b0, 0, tag);
  endtask

  task automatic probe(input bit id, input int addr, input string tag);
    apply(1'b0, 0, 0, id, addr, tag);
  endtask

  task automatic lock(input logic [7:0] code, input int addr);
    int w;
    @(negedge clk_i);
    lock_req_i = 1'b1; lock_code_i = code; lock_addr_i = 19'(addr);
    w = (code == 8'h40) ? 16 : (code == 8'h70) ? 14 : 0;
    if (w != 0 && addr == 'h7FFFF && top_w == 0) top_w = w;
    if (w != 0 && addr == 'h00000 && bot_w == 0) bot_w = w;
    @(negedge clk_i);
    lock_req_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    top_w = 0; bot_w = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // monitor: pops each expected item and compares it with the live outputs
  initial begin
    item_t it;
    forever begin
      wait (sb.size() != 0);
      it = sb.pop_front();
      checks++;
      if (permit_o !== it.permit || probe_hit_o !== it.hit || stat_o !== it.stat) begin
        errors++;
        $display("FAIL %s: permit/hit/stat got %b/%b/%h exp %b/%b/%h", it.tag,
                 permit_o, probe_hit_o, stat_o, it.permit, it.hit, it.stat);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    op(0, 'h00000, "R1 program bottom after reset");
    op(3, 'h12345, "R1 chip erase after reset");
    probe(1'b1, 'h00002, "R1 bottom probe after reset");
    probe(1'b1, 'h7FFF2, "R1 top probe after reset");
    apply(1'b0, 0, 'h12345, 1'b0, 0, "R6 idle permit low");
    // R5 malformed requests
    lock(8'h50, 'h7FFFF);
    op(0, 'h7FFFF, "R5 bad code ignored");
    lock(8'h40, 'h7FFFE);
    op(0, 'h7FFFF, "R5 bad top address ignored");
    lock(8'h40, 'h00001);
    op(0, 'h00000, "R5 bad bottom address ignored");
    // R3 R4 top 16K
    lock(8'h70, 'h7FFFF);
    op(0, 'h7C000, "R3 first top 16K byte refused");
    op(0, 'h7BFFF, "R3 R6 byte below top 16K allowed");
    op(0, 'h00000, "R4 bottom still free");
    probe(1'b1, 'h7FFF2, "R10 top probe 16K");
    // R9 relock ignored
    lock(8'h40, 'h7FFFF);
    op(0, 'h70000, "R9 relock did not widen");
    probe(1'b1, 'h7FFF2, "R9 status unchanged");
    // R7 erases
    op(1, 'h7B123, "R7 page below lock allowed");
    op(1, 'h7C800, "R7 page inside lock refused");
    op(2, 'h70000, "R7 sector overlapping lock refused");
    op(2, 'h6FFFF, "R7 sector below allowed");
    op(3, 'h00000, "R8 chip erase refused with top lock");
    // R2 R4 bottom 64K
    lock(8'h40, 'h00000);
    op(0, 'h0FFFF, "R2 last bottom 64K byte refused");
    op(0, 'h10000, "R2 byte above bottom 64K allowed");
    op(1, 'h0F000, "R7 page at bottom lock edge refused");
    op(1, 'h10FFF, "R7 page above bottom lock allowed");
    probe(1'b1, 'h00002, "R10 bottom probe 64K");
    probe(1'b1, 'h00003, "R10 adjacent address not a probe");
    probe(1'b0, 'h00002, "R10 probe outside id mode");
    probe(1'b1, 'h7FFF3, "R10 adjacent top address not a probe");
    // R11 reset clears
    do_reset();
    op(0, 'h7FFFF, "R11 top free after reset");
    op(0, 'h00000, "R11 bottom free after reset");
    op(3, 'h00000, "R11 chip erase allowed after reset");
    probe(1'b1, 'h7FFF2, "R11 top status cleared");
    lock(8'h40, 'h7FFFF);
    op(0, 'h70000, "R2 first top 64K byte refused");
    op(0, 'h6FFFF, "R2 byte below top 64K allowed");
    lock(8'h70, 'h00000);
    op(0, 'h03FFF, "R3 last bottom 16K byte refused");
    op(0, 'h04000, "R3 byte above bottom 16K allowed");
    op(2, 'h0ABCD, "R7 sector containing bottom 16K refused");
    op(3, 'h40000, "R8 chip erase refused with both locks");
    probe(1'b1, 'h00002, "R10 bottom probe 16K");
    probe(1'b1, 'h7FFF2, "R10 top probe 64K");
    apply(1'b0, 0, 'h40000, 1'b0, 0, "R6 idle permit low while locked");
    @(negedge clk_i);
    wait (sb.size() == 0);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule